// File: doc/BRIEF.md
# Datapath Self-Test Controller with Signature Check

This block tests the digital portion of a two-channel, 12-bit sample path without any analog stimulus. On command it swaps the converter samples for words from an internal pseudorandom generator. Those words travel through both channel datapaths, and a CRC signature is accumulated from what leaves the far end. After a fixed number of sample cycles the run stops by itself. The signature is then compared with a constant fixed at build time, and a status bit records pass or fail.

Software drives the block through a two-register interface: a control register that starts a run and chooses whether the generator restarts from its seed, and a status register that holds the verdict. The datapath outputs are never disconnected, so the generated words can be watched on the output bus during a run. A run that continues the generator from where the previous run stopped gives a signature that is not expected to match. In that case the captured output words are the only means of judging the result. A fault-injection input flips one output bit so that a failing run can be produced on purpose.

Top module: `dbist_top`

## Requirements
- R1: While no run is active, each channel output equals its converter input after one clock cycle, and the reset value of both outputs is zero.
- R2: A write of `reg_wdata` with bit 0 set to register select 0 while idle starts a run. A write with bit 0 clear starts nothing and leaves `busy` low.
- R3: When a run starts with control bit 2 set, a 23-bit generator is loaded with all ones. Each step shifts the register left and feeds bit 22 XOR bit 17 into bit 0. Channel A receives bits 11:0 and channel B receives bits 22:11. The first injected word comes from the seed state.
- R4: When a run starts with control bit 2 clear, the generator resumes from the state left by the previous run.
- R5: The output bus carries the generated words, one new pair per cycle, starting on the second cycle after the start write.
- R6: Exactly 512 generated word pairs appear on the outputs. On the cycle after the last pair, the outputs return to carrying converter samples.
- R7: The signature is a CRC-16 with polynomial 0x1021 and seed 0xFFFF. It is fed most significant bit first with the channel A output and then the channel B output of every injected cycle. Status bit 0 is set when the final signature equals parameter `EXPECT_SIG`.
- R8: Status bit 0 is cleared when a run starts, and it stays cleared after a run whose signature does not match. A run that continues the generator therefore reports fail.
- R9: `busy` and control readback bit 0 are high from the start write until the verdict is stored 514 cycles later, and then they clear themselves.
- R10: Control writes made during a run are ignored. The run, its output stream and its verdict are unchanged.
- R11: `fault_inj` inverts bit `FAULT_BIT` (default 0) of the channel A output that is registered on the next edge, whether a run is active or not. A run in which this happens reports fail.
- R12: Reset clears `busy`, the pass bit and both register readbacks. Control readback is {5'b0, last start's bit 2, 1'b0, busy}. Status readback is {7'b0, pass}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| adc_a | input | 12 | Converter sample, channel A |
| adc_b | input | 12 | Converter sample, channel B |
| fault_inj | input | 1 | Inverts one channel A output bit at the next edge |
| dout_a | output | 12 | Datapath output, channel A |
| dout_b | output | 12 | Datapath output, channel B |
| busy | output | 1 | Test run in progress |

## Verification
The assertions check the following on every cycle: the generator never reaches the all-zero state, it holds its state outside a run, the sequencer leaves the injection phase after its last count, the pass bit changes only at the start or at the verdict, idle outputs follow the converter inputs, and injection never happens without `busy`. Only the bench scenarios can show that the output stream matches the generator polynomial word for word, that reseeding and continuation behave differently, and that the stored verdict reflects the signature of a clean run, a continued run and a corrupted run. The bench also shows that a restart attempt during a run leaves the stream undisturbed.

// File: rtl/dbist_pkg.sv
package dbist_pkg;

    localparam int SAMPLE_W = 12;
    localparam int LFSR_W   = 23;
    localparam int LFSR_TAP = 17;
    localparam int CRC_W    = 16;
    localparam logic [CRC_W-1:0]  CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0]  CRC_SEED = 16'hFFFF;
    localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

    localparam int REG_W      = 8;
    localparam int CTL_EN_BIT = 0;
    localparam int CTL_INIT_BIT = 2;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [LFSR_W-1:0]   lfsr_t;
    typedef logic [CRC_W-1:0]    crc_t;

    typedef struct packed {
        sample_t a;
        sample_t b;
    } pair_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2,
        SEQ_CHECK = 2'd3
    } seq_e;

    function automatic lfsr_t lfsr_next(input lfsr_t s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_TAP]};
    endfunction

    function automatic pair_t lfsr_slices(input lfsr_t s);
        pair_t p;
        p.a = s[SAMPLE_W-1:0];
        p.b = s[LFSR_W-1 -: SAMPLE_W];
        return p;
    endfunction

    function automatic crc_t crc_absorb(input crc_t c, input sample_t d);
        crc_t r;
        logic fb;
        r = c;
        for (int i = SAMPLE_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/dbist_prbs.sv
module dbist_prbs
    import dbist_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  reseed,
    input  logic  advance,
    output pair_t word
);

    lfsr_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LFSR_SEED;
        end else if (reseed) begin
            state_q <= LFSR_SEED;
        end else if (advance) begin
            state_q <= lfsr_next(state_q);
        end
    end

    assign word = lfsr_slices(state_q);

    assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    assert_lfsr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!advance && !reseed) |=> $stable(state_q));

endmodule

// File: rtl/dbist_lane.sv
module dbist_lane
    import dbist_pkg::*;
#(
    parameter bit FLIP_EN   = 1'b0,
    parameter int FAULT_BIT = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  sample_t din,
    input  logic    flip,
    output sample_t dout
);

    localparam sample_t FLIP_MASK = sample_t'(1) << FAULT_BIT;

    sample_t q;
    sample_t corrupt;

    generate
        if (FLIP_EN) begin : g_fault
            assign corrupt = flip ? FLIP_MASK : '0;
        end else begin : g_clean
            assign corrupt = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= din ^ corrupt;
    end

    assign dout = q;

endmodule

// File: rtl/dbist_sig.sv
module dbist_sig
    import dbist_pkg::*;
#(
    parameter crc_t EXPECT_SIG = 16'h0000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  inject,
    input  pair_t lane_out,
    output logic  match
);

    logic vld_q;
    crc_t sig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            sig_q <= CRC_SEED;
        end else begin
            vld_q <= inject;
            if (clear) begin
                sig_q <= CRC_SEED;
            end else if (vld_q) begin
                sig_q <= crc_absorb(crc_absorb(sig_q, lane_out.a), lane_out.b);
            end
        end
    end

    assign match = (sig_q == EXPECT_SIG);

    assert_sig_seeded_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> (sig_q == CRC_SEED));

endmodule

// File: rtl/dbist_seq.sv
module dbist_seq
    import dbist_pkg::*;
#(
    parameter int RUN_LEN = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sig_match,
    output logic             start,
    output logic             reseed,
    output logic             inject,
    output logic             busy
);

    localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    seq_e             state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pass_q;
    logic             init_q;

    assign start  = reg_we && !reg_sel && reg_wdata[CTL_EN_BIT] && (state_q == SEQ_IDLE);
    assign reseed = start && reg_wdata[CTL_INIT_BIT];
    assign inject = (state_q == SEQ_RUN);
    assign busy   = (state_q != SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            pass_q  <= 1'b0;
            init_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                        pass_q  <= 1'b0;
                        init_q  <= reg_wdata[CTL_INIT_BIT];
                    end
                end
                SEQ_RUN: begin
                    if (cnt_q == LAST) state_q <= SEQ_DRAIN;
                    else               cnt_q   <= cnt_q + 1'b1;
                end
                SEQ_DRAIN: state_q <= SEQ_CHECK;
                SEQ_CHECK: begin
                    pass_q  <= sig_match;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_sel) begin
            reg_rdata[CTL_EN_BIT]   = busy;
            reg_rdata[CTL_INIT_BIT] = init_q;
        end else begin
            reg_rdata[0] = pass_q;
        end
    end

    assert_run_stops_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN && cnt_q == LAST) |=> (state_q == SEQ_DRAIN));

    assert_start_clears_pass_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> !pass_q);

    assert_pass_only_at_verdict_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_CHECK && !start) |=> $stable(pass_q));

    assert_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we && !reg_sel) |=> $stable(init_q));

    assert_busy_selfclear_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_CHECK) |=> !busy);

endmodule

// File: rtl/dbist_top.sv
module dbist_top
    import dbist_pkg::*;
#(
    parameter int   RUN_LEN    = 512,
    parameter crc_t EXPECT_SIG = 16'h0000,
    parameter int   FAULT_BIT  = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic                reg_sel,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [SAMPLE_W-1:0] adc_a,
    input  logic [SAMPLE_W-1:0] adc_b,
    input  logic                fault_inj,
    output logic [SAMPLE_W-1:0] dout_a,
    output logic [SAMPLE_W-1:0] dout_b,
    output logic                busy
);

    localparam int N_CH = 2;

    logic  start;
    logic  reseed;
    logic  inject;
    logic  match;
    pair_t prbs_word;
    pair_t conv_word;
    pair_t lane_in;
    pair_t lane_out;

    sample_t lane_in_v  [N_CH];
    sample_t lane_out_v [N_CH];

    dbist_seq #(.RUN_LEN(RUN_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sig_match (match),
        .start     (start),
        .reseed    (reseed),
        .inject    (inject),
        .busy      (busy)
    );

    dbist_prbs u_prbs (
        .clk     (clk),
        .rst     (rst),
        .reseed  (reseed),
        .advance (inject),
        .word    (prbs_word)
    );

    assign conv_word.a = adc_a;
    assign conv_word.b = adc_b;
    assign lane_in     = inject ? prbs_word : conv_word;

    assign lane_in_v[0] = lane_in.a;
    assign lane_in_v[1] = lane_in.b;

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
            dbist_lane #(
                .FLIP_EN   (ch == 0),
                .FAULT_BIT (FAULT_BIT)
            ) u_lane (
                .clk  (clk),
                .rst  (rst),
                .din  (lane_in_v[ch]),
                .flip (fault_inj),
                .dout (lane_out_v[ch])
            );
        end
    endgenerate

    assign lane_out.a = lane_out_v[0];
    assign lane_out.b = lane_out_v[1];
    assign dout_a     = lane_out.a;
    assign dout_b     = lane_out.b;

    dbist_sig #(.EXPECT_SIG(EXPECT_SIG)) u_sig (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .inject   (inject),
        .lane_out (lane_out),
        .match    (match)
    );

    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (!inject && !fault_inj) |=> (dout_a == $past(adc_a) && dout_b == $past(adc_b)));

    assert_inject_needs_busy_R9: assert property (@(posedge clk) disable iff (rst)
        inject |-> busy);

endmodule

// File: tb/sim_dbist_top.sv
`timescale 1ns/1ps
module sim_dbist_top;

    localparam int RUNS = 512;

    function automatic logic [22:0] m_step(input logic [22:0] s);
        return {s[21:0], s[22] ^ s[17]};
    endfunction

    function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [11:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 11; b >= 0; b--) begin
            if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [15:0] m_golden();
        logic [22:0] s;
        logic [15:0] c;
        s = '1;
        c = 16'hFFFF;
        for (int k = 0; k < RUNS; k++) begin
            c = m_crc(m_crc(c, s[11:0]), s[22:11]);
            s = m_step(s);
        end
        return c;
    endfunction

    localparam logic [15:0] GOLD = m_golden();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [11:0] adc_a = '0;
    logic [11:0] adc_b = '0;
    logic        fault_inj = 1'b0;
    logic [11:0] dout_a;
    logic [11:0] dout_b;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;
    logic [22:0] m_state = '1;

    always #10 clk = ~clk;

    dbist_top #(.RUN_LEN(RUNS), .EXPECT_SIG(GOLD), .FAULT_BIT(0)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .adc_a(adc_a), .adc_b(adc_b), .fault_inj(fault_inj),
        .dout_a(dout_a), .dout_b(dout_b), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic read_reg(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b0;
        reg_wdata = v;
        reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // one run: start, follow the stream, check the verdict
    task automatic do_run(input logic [7:0] cmd, input bit exp_pass,
                          input int fault_at, input int write_at, input string tag);
        logic [7:0] rv;
        logic [11:0] ea;
        adc_a = 12'hA5A;
        adc_b = 12'h3C3;
        if (cmd[2]) m_state = '1;
        write_ctrl(cmd);
        check(busy == 1'b1, {"R9 busy at start ", tag}, busy, 1);
        read_reg(1'b1, rv);
        check(rv == 8'h00, {"R8 pass cleared at start ", tag}, rv, 0);
        for (int k = 0; k < RUNS; k++) begin
            @(negedge clk);
            ea = m_state[11:0] ^ ((k == fault_at) ? 12'h001 : 12'h000);
            check(dout_a == ea, {"R5 R3 R11 stream A ", tag}, dout_a, ea);
            check(dout_b == m_state[22:11], {"R5 R3 stream B ", tag}, dout_b, m_state[22:11]);
            check(busy == 1'b1, {"R9 busy in run ", tag}, busy, 1);
            fault_inj = (k == fault_at - 1);
            if (k == write_at) begin
                reg_sel = 1'b0;
                reg_wdata = 8'h05;
                reg_we = 1'b1;
            end else begin
                reg_we = 1'b0;
            end
            m_state = m_step(m_state);
        end
        reg_we = 1'b0;
        fault_inj = 1'b0;
        @(negedge clk);
        check(dout_a == 12'hA5A, {"R6 outputs back A ", tag}, dout_a, 12'hA5A);
        check(dout_b == 12'h3C3, {"R6 outputs back B ", tag}, dout_b, 12'h3C3);
        check(busy == 1'b1, {"R9 busy in drain ", tag}, busy, 1);
        @(negedge clk);
        check(busy == 1'b0, {"R9 busy self-clears ", tag}, busy, 0);
        read_reg(1'b1, rv);
        check(rv == {7'b0, exp_pass}, {"R7 R8 verdict ", tag}, rv, {7'b0, exp_pass});
        read_reg(1'b0, rv);
        check(rv == {5'b0, cmd[2], 2'b00}, {"R9 R12 control readback ", tag}, rv, {5'b0, cmd[2], 2'b00});
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        logic [11:0] va, vb;
        logic f;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check(busy == 1'b0, "R12 busy after reset", busy, 0);
        check(dout_a == 12'h000 && dout_b == 12'h000, "R1 R12 outputs after reset", dout_a, 0);
        read_reg(1'b0, rv);
        check(rv == 8'h00, "R12 control after reset", rv, 0);
        read_reg(1'b1, rv);
        check(rv == 8'h00, "R12 status after reset", rv, 0);

        // R1 / R11 idle passthrough sweep
        for (int i = 0; i < 64; i++) begin
            va = 12'(i * 12'h041 + (i << 7));
            vb = 12'(~(i * 12'h0B3));
            f  = (i % 3 == 0);
            @(negedge clk);
            adc_a = va; adc_b = vb; fault_inj = f;
            @(negedge clk);
            fault_inj = 1'b0;
            check(dout_a == (va ^ {11'b0, f}), "R1 R11 idle channel A", dout_a, va ^ {11'b0, f});
            check(dout_b == vb, "R1 idle channel B", dout_b, vb);
        end

        // R2 write without enable bit starts nothing
        write_ctrl(8'h04);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(busy == 1'b0, "R2 no start without enable", busy, 0);
        end
        read_reg(1'b0, rv);
        check(rv == 8'h00, "R2 control unchanged", rv, 0);

        // R7 R10 clean run with a restart attempt mid-run
        do_run(8'h05, 1'b1, -10, 200, "clean+write");
        // R4 R8 continued generator fails
        do_run(8'h01, 1'b0, -10, -10, "continue");
        // R11 corrupted run fails
        do_run(8'h05, 1'b0, 100, -10, "fault");
        // R3 R7 reseeded run passes again
        do_run(8'h05, 1'b1, -10, -10, "reseed");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule